// File: doc/BRIEF.md
# Descriptor-Chain Transmit DMA Channel

This block is one transmit channel of a packet DMA engine. Software builds a linked list of four-word buffer descriptors in a local descriptor RAM and writes the address of the first one into the head register. The channel then walks the list. For each descriptor it reads the referenced buffer from packet memory one byte at a time and presents it on a valid/ready byte stream with start and end markers. When a descriptor is finished, its mode word is written back with the hardware-owner flag cleared.

When the channel reaches a descriptor with a null next pointer, it also sets the end-of-queue flag in that descriptor, clears the head register and stops. Software may append descriptors behind the tail while the channel runs. If software finds end-of-queue already set on the old tail, it writes the head register again to resume. A control bit gates the channel. A self-clearing soft-reset bit drops all channel state. A completion register holds the descriptor address that software writes back to acknowledge a descriptor.

Top module: `desc_chain_tx`

## Requirements
- R1: After reset no byte is valid, and all four registers read zero. The registers are control at offset 0 (bit 0 is run enable), soft reset at offset 1 (bit 0), head pointer at offset 2 and completion pointer at offset 3.
- R2: With run enable set, writing a non-zero descriptor address to the head register starts the channel.
  - A descriptor occupies four consecutive descriptor-RAM words: +0 next pointer, +1 buffer byte address, +2 buffer length in its low 11 bits, +3 mode word.
  - The channel emits exactly the length's worth of bytes from consecutive buffer addresses, in address order.
- R3: The first byte of a descriptor carries the start marker only if mode bit 31 is set. The last byte carries the end marker only if mode bit 30 is set. No other byte carries either marker.
- R4: After its bytes are sent, a descriptor's mode word is written back with bit 29 (owner) cleared. Every other bit is kept, including the low 11 bits, except bit 28.
- R5: If the next pointer of a finished descriptor is non-zero, the channel continues with that descriptor. If it is zero, the channel sets mode bit 28 (end of queue) in the finished descriptor, stops, and the head register reads zero.
- R6: A descriptor whose owner bit is clear when fetched is not sent and not written back. The channel stops and the head register reads zero.
- R7: While run enable is 0, a head write does not start the channel. Clearing run enable mid-chain lets the current descriptor finish, then pauses with the head register holding the next descriptor's address. Setting run enable again resumes from that descriptor.
- R8: A head-register write while the channel is active is ignored.
- R9: While a byte is valid and not accepted, the data byte and markers hold steady and valid stays high.
- R10: Writing 1 to the soft-reset bit makes it read 1 for one cycle and then 0. The reset stops the channel, drops the valid byte, and clears the head and completion registers. Run enable is kept.
- R11: The completion register reads back the last 32-bit value written to it.
- R12: A descriptor with zero buffer length emits no bytes but is still written back.
- R13: The next pointer is sampled in the write-back cycle. A link written to the old tail in the same cycle as its write-back is missed: end of queue is set and the channel stops. A later head write then sends the linked descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| swDescWr | input | 1 | Software descriptor-RAM write strobe |
| swDescAddr | input | DESC_AW | Descriptor-RAM word address |
| swDescWdata | input | 32 | Descriptor-RAM write data |
| swDescRdata | output | 32 | Descriptor-RAM read data for swDescAddr |
| bufRdEn | output | 1 | Packet-memory read request |
| bufAddr | output | BUF_AW | Packet-memory byte address |
| bufRdata | input | 8 | Packet-memory data, one cycle after bufRdEn |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the byte |
| outData | output | 8 | Output byte |
| outSop | output | 1 | Byte is the start of a packet |
| outEop | output | 1 | Byte is the end of a packet |

## Verification
Two things can fall in the same clock edge: the write-back of a descriptor's mode word and a software write of a next pointer into that same descriptor. The bench provokes both orderings.
- Early case: the link is written while the last byte is still pending. The chain must continue without stalling.
- Collision case: the bench watches for the handshake of the descriptor's last byte and issues the next-pointer write one clock later, so it lands on the write-back edge. There the channel must report end of queue and clear its head. The software word must survive next to the mode-word write-back, and a fresh head write must then send the linked descriptor.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  // mode-word flag positions, decoded by software polling the ring
  localparam int MODE_SOP = 31;
  localparam int MODE_EOP = 30;
  localparam int MODE_OWN = 29;
  localparam int MODE_EOQ = 28;

  // register offsets
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SRST = 2'd1;
  localparam logic [1:0] REG_HEAD = 2'd2;
  localparam logic [1:0] REG_DONE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RDREQ,
    ST_LOAD,
    ST_SEND,
    ST_WBACK
  } dtxState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic ldDesc;   // latch buffer pointer, length, mode of current descriptor
    logic rdReq;    // issue packet-memory read of current byte
    logic ldByte;   // capture returned byte into output register
    logic advByte;  // byte accepted downstream, advance counter
    logic wbMode;   // write mode word back to descriptor RAM
    logic flush;    // soft reset of channel state
  } dtxStrobe_t;

endpackage

// File: rtl/dtx_datapath.sv
module dtx_datapath
  import dtx_pkg::*;
#(
  parameter int DESC_WORDS = 64,
  parameter int DESC_AW    = 6,
  parameter int BUF_AW     = 16,
  parameter int LEN_W      = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  dtxStrobe_t         strb,
  input  logic [DESC_AW-1:0] descBase,
  input  logic               swDescWr,
  input  logic [DESC_AW-1:0] swDescAddr,
  input  logic [31:0]        swDescWdata,
  output logic [31:0]        swDescRdata,
  output logic               bufRdEn,
  output logic [BUF_AW-1:0]  bufAddr,
  input  logic [7:0]         bufRdata,
  output logic               outValid,
  input  logic               outReady,
  output logic [7:0]         outData,
  output logic               outSop,
  output logic               outEop,
  output logic               descOwner,
  output logic               descLenZero,
  output logic [DESC_AW-1:0] descNext,
  output logic               lastByte,
  output logic               byteFire
);

  localparam int WORDS_PER_DESC = 4;

  logic [31:0] descMem [DESC_WORDS];
  logic [31:0] descWord [WORDS_PER_DESC];

  // one combinational read port per descriptor word
  for (genvar g = 0; g < WORDS_PER_DESC; g++) begin : g_wordRd
    assign descWord[g] = descMem[descBase + DESC_AW'(g)];
  end

  assign swDescRdata = descMem[swDescAddr];
  assign descNext    = descWord[0][DESC_AW-1:0];
  assign descOwner   = descWord[3][MODE_OWN];
  assign descLenZero = (descWord[2][LEN_W-1:0] == '0);

  logic [BUF_AW-1:0] bufBase;
  logic [LEN_W-1:0]  bufLen;
  logic [31:0]       modeWord;
  logic [LEN_W-1:0]  byteCnt;
  logic              sopReg;
  logic              eopReg;
  logic [31:0]       wbWord;

  assign lastByte = (byteCnt == bufLen - LEN_W'(1));
  assign byteFire = outValid && outReady;
  assign bufRdEn  = strb.rdReq;
  assign bufAddr  = bufBase + BUF_AW'(byteCnt);
  assign outSop   = outValid && sopReg;
  assign outEop   = outValid && eopReg;

  always_comb begin
    wbWord = modeWord;
    wbWord[MODE_OWN] = 1'b0;
    wbWord[MODE_EOQ] = (descNext == '0);
  end

  // descriptor RAM: engine write-back is placed last so it wins a same-word clash
  always_ff @(posedge clk) begin
    if (swDescWr) descMem[swDescAddr] <= swDescWdata;
    if (strb.wbMode) descMem[descBase + DESC_AW'(3)] <= wbWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufBase  <= '0;
      bufLen   <= '0;
      modeWord <= '0;
      byteCnt  <= '0;
      outData  <= '0;
      outValid <= 1'b0;
      sopReg   <= 1'b0;
      eopReg   <= 1'b0;
    end else if (strb.flush) begin
      byteCnt  <= '0;
      outValid <= 1'b0;
      sopReg   <= 1'b0;
      eopReg   <= 1'b0;
    end else begin
      if (strb.ldDesc) begin
        bufBase  <= descWord[1][BUF_AW-1:0];
        bufLen   <= descWord[2][LEN_W-1:0];
        modeWord <= descWord[3];
        byteCnt  <= '0;
      end
      if (strb.ldByte) begin
        outData  <= bufRdata;
        outValid <= 1'b1;
        sopReg   <= modeWord[MODE_SOP] && (byteCnt == '0);
        eopReg   <= modeWord[MODE_EOP] && lastByte;
      end
      if (strb.advByte) begin
        outValid <= 1'b0;
        byteCnt  <= byteCnt + LEN_W'(1);
      end
    end
  end

  logic unusedDescBits;
  assign unusedDescBits = ^{descWord[0][31:DESC_AW], descWord[1][31:BUF_AW],
                            descWord[2][31:LEN_W]};

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !strb.flush) |=>
      (outValid && $stable(outData) && $stable(outSop) && $stable(outEop)));

endmodule

// File: rtl/dtx_ctrl.sv
module dtx_ctrl
  import dtx_pkg::*;
#(
  parameter int DESC_AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic               descOwner,
  input  logic               descLenZero,
  input  logic [DESC_AW-1:0] descNext,
  input  logic               lastByte,
  input  logic               byteFire,
  output dtxStrobe_t         strb,
  output logic [DESC_AW-1:0] descBase,
  output logic               engineIdle
);

  dtxState_e          state, nxtState;
  logic [DESC_AW-1:0] headPtr;
  logic [31:0]        donePtr;
  logic               runEn;
  logic               srstPend;
  logic               startNow;
  logic               headWrOk;

  assign startNow   = (state == ST_IDLE) && runEn && (headPtr != '0) && !srstPend;
  assign headWrOk   = regWr && (regAddr == REG_HEAD) && (state == ST_IDLE)
                      && !startNow && !srstPend;
  assign descBase   = headPtr;
  assign engineIdle = (state == ST_IDLE);

  always_comb begin
    nxtState = state;
    strb     = '0;
    unique case (state)
      ST_IDLE:  if (startNow) nxtState = ST_FETCH;
      ST_FETCH: begin
        if (!descOwner) nxtState = ST_IDLE;
        else begin
          strb.ldDesc = 1'b1;
          nxtState = descLenZero ? ST_WBACK : ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        strb.rdReq = 1'b1;
        nxtState = ST_LOAD;
      end
      ST_LOAD: begin
        strb.ldByte = 1'b1;
        nxtState = ST_SEND;
      end
      ST_SEND: begin
        if (byteFire) begin
          strb.advByte = 1'b1;
          nxtState = lastByte ? ST_WBACK : ST_RDREQ;
        end
      end
      ST_WBACK: begin
        strb.wbMode = 1'b1;
        nxtState = ((descNext == '0) || !runEn) ? ST_IDLE : ST_FETCH;
      end
      default: nxtState = ST_IDLE;
    endcase
    if (srstPend) begin
      strb       = '0;
      strb.flush = 1'b1;
      nxtState   = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      headPtr  <= '0;
      donePtr  <= '0;
      runEn    <= 1'b0;
      srstPend <= 1'b0;
    end else begin
      state <= nxtState;

      if (regWr && regAddr == REG_CTRL) runEn <= regWdata[0];

      if (srstPend) srstPend <= 1'b0;
      else if (regWr && regAddr == REG_SRST && regWdata[0]) srstPend <= 1'b1;

      if (srstPend) donePtr <= '0;
      else if (regWr && regAddr == REG_DONE) donePtr <= regWdata;

      if (srstPend) headPtr <= '0;
      else if (state == ST_FETCH && !descOwner) headPtr <= '0;
      else if (state == ST_WBACK) headPtr <= descNext;
      else if (headWrOk) headPtr <= regWdata[DESC_AW-1:0];
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_CTRL: regRdata = 32'(runEn);
      REG_SRST: regRdata = 32'(srstPend);
      REG_HEAD: regRdata = 32'(headPtr);
      default:  regRdata = donePtr;
    endcase
  end

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RDREQ || state == ST_LOAD || state == ST_SEND) && !srstPend)
      |=> $stable(headPtr));

  // R10
  srst_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    srstPend |=> (!srstPend && state == ST_IDLE && headPtr == '0 && donePtr == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !runEn && !srstPend) |=> (state == ST_IDLE));

  // R5
  eoq_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WBACK && descNext == '0 && !srstPend)
      |=> (state == ST_IDLE && headPtr == '0));

endmodule

// File: rtl/desc_chain_tx.sv
module desc_chain_tx
  import dtx_pkg::*;
#(
  parameter  int DESC_WORDS = 64,
  parameter  int BUF_AW     = 16,
  parameter  int LEN_W      = 11,
  localparam int DESC_AW    = $clog2(DESC_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic               swDescWr,
  input  logic [DESC_AW-1:0] swDescAddr,
  input  logic [31:0]        swDescWdata,
  output logic [31:0]        swDescRdata,
  output logic               bufRdEn,
  output logic [BUF_AW-1:0]  bufAddr,
  input  logic [7:0]         bufRdata,
  output logic               outValid,
  input  logic               outReady,
  output logic [7:0]         outData,
  output logic               outSop,
  output logic               outEop
);

  dtxStrobe_t         strb;
  logic [DESC_AW-1:0] descBase;
  logic [DESC_AW-1:0] descNext;
  logic               descOwner;
  logic               descLenZero;
  logic               lastByte;
  logic               byteFire;
  logic               engineIdle;

  dtx_ctrl #(.DESC_AW(DESC_AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .descOwner(descOwner), .descLenZero(descLenZero), .descNext(descNext),
    .lastByte(lastByte), .byteFire(byteFire),
    .strb(strb), .descBase(descBase), .engineIdle(engineIdle)
  );

  dtx_datapath #(
    .DESC_WORDS(DESC_WORDS), .DESC_AW(DESC_AW), .BUF_AW(BUF_AW), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .descBase(descBase),
    .swDescWr(swDescWr), .swDescAddr(swDescAddr), .swDescWdata(swDescWdata),
    .swDescRdata(swDescRdata),
    .bufRdEn(bufRdEn), .bufAddr(bufAddr), .bufRdata(bufRdata),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outSop(outSop), .outEop(outEop),
    .descOwner(descOwner), .descLenZero(descLenZero), .descNext(descNext),
    .lastByte(lastByte), .byteFire(byteFire)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    engineIdle |-> !outValid);

endmodule

// File: tb/tb_desc_chain_tx.sv
`timescale 1ns/1ps
module tb_desc_chain_tx;

  localparam logic [1:0] A_CTRL = 2'd0, A_SRST = 2'd1, A_HEAD = 2'd2, A_DONE = 2'd3;
  localparam logic [31:0] EOQ = 32'h1000_0000;
  // vector: [31] sop, [30] eop, [26:16] length, [15:0] buffer start
  localparam logic [31:0] VEC_TAB [6] = '{
    32'hC005_0000, 32'h8001_0064, 32'h4007_00C8,
    32'h0003_0025, 32'hC010_01F4, 32'hC002_03E8 };

  logic clk = 0, rstN = 0, regWr = 0, swDescWr = 0, outReady = 0;
  logic [1:0] regAddr = 0;
  logic [31:0] regWdata = 0, swDescWdata = 0;
  logic [5:0] swDescAddr = 0;
  logic [7:0] bufRdata = 0;
  wire [31:0] regRdata, swDescRdata;
  wire bufRdEn, outValid, outSop, outEop;
  wire [15:0] bufAddr;
  wire [7:0] outData;

  desc_chain_tx dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .swDescWr(swDescWr), .swDescAddr(swDescAddr),
    .swDescWdata(swDescWdata), .swDescRdata(swDescRdata), .bufRdEn(bufRdEn),
    .bufAddr(bufAddr), .bufRdata(bufRdata), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outSop(outSop), .outEop(outEop));

  always #2 clk = ~clk;

  function automatic logic [7:0] expByte(input logic [15:0] a);
    return 8'(a * 13 + 5);
  endfunction

  function automatic logic [31:0] modeOf(input bit s, input bit e, input bit o, input int len);
    return {s, e, o, 18'b0, len[10:0]};
  endfunction

  always @(posedge clk) if (bufRdEn) bufRdata <= expByte(bufAddr);

  int checks = 0, fails = 0;
  int readyMode = 0, rdyCnt = 0, capN = 0;
  logic [7:0] capData [64];
  logic capSop [64], capEop [64];

  always @(negedge clk) begin
    logic r;
    rdyCnt++;
    case (readyMode)
      0: r = 1'b1;
      1: r = rdyCnt[0];
      2: r = (rdyCnt % 3 == 0);
      default: r = 1'b0;
    endcase
    outReady = r;
    if (outValid && r && capN < 64) begin
      capData[capN] = outData;
      capSop[capN]  = outSop;
      capEop[capN]  = outEop;
      capN++;
    end
  end

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic regPeek(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regPeek(a, d);
  endtask

  task automatic descWrite(input int a, input logic [31:0] d);
    @(negedge clk); swDescWr = 1; swDescAddr = 6'(a); swDescWdata = d;
    @(negedge clk); swDescWr = 0;
  endtask

  task automatic descRead(input int a, output logic [31:0] d);
    @(negedge clk); swDescAddr = 6'(a); #1; d = swDescRdata;
  endtask

  task automatic setDesc(input int base, input int nxt, input int bufStart, input int len,
                         input bit s, input bit e, input bit o);
    descWrite(base, 32'(nxt));
    descWrite(base + 1, 32'(bufStart));
    descWrite(base + 2, 32'(len));
    descWrite(base + 3, modeOf(s, e, o, len));
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] d;
    d = 1;
    for (int i = 0; i < 4000 && d != 0; i++) regRead(A_HEAD, d);
    check({tag, " head idle"}, d, 0);
  endtask

  task automatic checkStream(input string tag, input int at, input int bufStart,
                             input int len, input bit s, input bit e);
    for (int i = 0; i < len; i++) begin
      check({tag, " data"}, 32'(capData[at + i]), 32'(expByte(16'(bufStart + i))));
      check({tag, " sop R3"}, 32'(capSop[at + i]), 32'(s && i == 0));
      check({tag, " eop R3"}, 32'(capEop[at + i]), 32'(e && i == len - 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, vec;
    int st, len, n;

    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    regRead(A_CTRL, d); check("R1 control", d, 0);
    regRead(A_SRST, d); check("R1 soft reset", d, 0);
    regRead(A_HEAD, d); check("R1 head", d, 0);
    regRead(A_DONE, d); check("R1 completion", d, 0);
    check("R1 valid", 32'(outValid), 0);

    // R11 completion register
    regWrite(A_DONE, 32'h1234_0024);
    regRead(A_DONE, d); check("R11 completion readback", d, 32'h1234_0024);

    regWrite(A_CTRL, 1);

    // vector table: single-descriptor queues, R2 R3 R4 R5
    for (int v = 0; v < 6; v++) begin
      vec = VEC_TAB[v];
      st = int'(vec[15:0]);
      len = int'(vec[26:16]);
      readyMode = v % 3;
      capN = 0;
      setDesc(4, 0, st, len, vec[31], vec[30], 1);
      regWrite(A_HEAD, 4);
      waitIdle("R5 vector");
      check("R2 vector byte count", 32'(capN), 32'(len));
      checkStream("R2 vector", 0, st, len, vec[31], vec[30]);
      descRead(7, d);
      check("R4 R5 vector writeback", d, modeOf(vec[31], vec[30], 0, len) | EOQ);
    end

    // R5 chain of three descriptors
    readyMode = 1; capN = 0;
    setDesc(4, 8, 10, 2, 1, 0, 1);
    setDesc(8, 12, 20, 3, 0, 0, 1);
    setDesc(12, 0, 30, 1, 0, 1, 1);
    regWrite(A_HEAD, 4);
    waitIdle("R5 chain");
    check("R5 chain count", 32'(capN), 6);
    checkStream("R5 chain d0", 0, 10, 2, 1, 0);
    checkStream("R5 chain d1", 2, 20, 3, 0, 0);
    checkStream("R5 chain d2", 5, 30, 1, 0, 1);
    descRead(7, d);  check("R4 chain d0 mode", d, modeOf(1, 0, 0, 2));
    descRead(11, d); check("R4 chain d1 mode", d, modeOf(0, 0, 0, 3));
    descRead(15, d); check("R5 chain d2 mode", d, modeOf(0, 1, 0, 1) | EOQ);

    // R6 owner clear stops the chain
    readyMode = 0; capN = 0;
    setDesc(4, 8, 600, 3, 1, 0, 1);
    setDesc(8, 0, 700, 2, 0, 1, 0);
    regWrite(A_HEAD, 4);
    waitIdle("R6");
    repeat (10) @(negedge clk);
    check("R6 byte count", 32'(capN), 3);
    descRead(7, d);  check("R6 sent mode", d, modeOf(1, 0, 0, 3));
    descRead(11, d); check("R6 unowned untouched", d, modeOf(0, 1, 0, 2));

    // R12 zero length
    capN = 0;
    setDesc(4, 0, 0, 0, 1, 1, 1);
    regWrite(A_HEAD, 4);
    waitIdle("R12");
    repeat (5) @(negedge clk);
    check("R12 no bytes", 32'(capN), 0);
    descRead(7, d); check("R12 writeback", d, modeOf(1, 1, 0, 0) | EOQ);

    // R7 disabled channel does not start
    regWrite(A_CTRL, 0);
    capN = 0;
    setDesc(4, 0, 50, 3, 1, 1, 1);
    regWrite(A_HEAD, 4);
    repeat (40) @(negedge clk);
    check("R7 no start", 32'(capN), 0);
    regRead(A_HEAD, d); check("R7 head kept", d, 4);
    regWrite(A_CTRL, 1);
    waitIdle("R7 resume");
    check("R7 resume count", 32'(capN), 3);
    checkStream("R7 resume", 0, 50, 3, 1, 1);

    // R7 pause at descriptor boundary
    capN = 0;
    setDesc(4, 8, 60, 3, 1, 0, 1);
    setDesc(8, 0, 80, 2, 0, 1, 1);
    regWrite(A_HEAD, 4);
    wait (capN >= 1);
    regWrite(A_CTRL, 0);
    repeat (60) @(negedge clk);
    regRead(A_HEAD, d); check("R7 paused head", d, 8);
    check("R7 paused count", 32'(capN), 3);
    regWrite(A_CTRL, 1);
    waitIdle("R7 boundary");
    check("R7 boundary count", 32'(capN), 5);
    checkStream("R7 boundary d1", 3, 80, 2, 0, 1);

    // R8 head write while active is ignored
    readyMode = 1; capN = 0;
    setDesc(4, 0, 100, 8, 1, 1, 1);
    setDesc(40, 0, 300, 4, 1, 1, 1);
    regWrite(A_HEAD, 4);
    wait (capN >= 1);
    regWrite(A_HEAD, 40);
    waitIdle("R8");
    repeat (20) @(negedge clk);
    check("R8 count", 32'(capN), 8);
    regRead(A_HEAD, d); check("R8 head stays zero", d, 0);
    descRead(43, d); check("R8 other desc untouched", d, modeOf(1, 1, 1, 4));

    // R9 backpressure
    readyMode = 3; capN = 0;
    setDesc(4, 0, 400, 2, 1, 1, 1);
    regWrite(A_HEAD, 4);
    repeat (10) @(negedge clk);
    check("R9 valid held", 32'(outValid), 1);
    check("R9 data held", 32'(outData), 32'(expByte(400)));
    repeat (15) @(negedge clk);
    check("R9 valid still", 32'(outValid), 1);
    check("R9 data still", 32'(outData), 32'(expByte(400)));
    check("R9 sop still", 32'(outSop), 1);
    readyMode = 0;
    waitIdle("R9");
    checkStream("R9", 0, 400, 2, 1, 1);

    // R10 soft reset mid-packet
    regWrite(A_DONE, 32'h00C0_FFEE);
    readyMode = 2; capN = 0;
    setDesc(4, 0, 500, 16, 1, 1, 1);
    regWrite(A_HEAD, 4);
    wait (capN >= 2);
    regWrite(A_SRST, 1);
    regPeek(A_SRST, d); check("R10 bit set", d, 1);
    regRead(A_SRST, d); check("R10 bit cleared", d, 0);
    regRead(A_HEAD, d); check("R10 head", d, 0);
    regRead(A_DONE, d); check("R10 completion", d, 0);
    regRead(A_CTRL, d); check("R10 enable kept", d, 1);
    check("R10 valid dropped", 32'(outValid), 0);
    n = capN;
    repeat (30) @(negedge clk);
    check("R10 stopped", 32'(capN), 32'(n));

    // R13 early link continues the chain
    readyMode = 0; capN = 0;
    setDesc(4, 0, 800, 2, 1, 0, 1);
    setDesc(8, 0, 820, 3, 0, 1, 1);
    regWrite(A_HEAD, 4);
    wait (capN >= 1);
    descWrite(4, 8);
    waitIdle("R13 early");
    check("R13 early count", 32'(capN), 5);
    checkStream("R13 early d1", 2, 820, 3, 0, 1);
    descRead(7, d);  check("R13 early d0 mode", d, modeOf(1, 0, 0, 2));
    descRead(11, d); check("R13 early d1 mode", d, modeOf(0, 1, 0, 3) | EOQ);

    // R13 link lands on the write-back edge: missed, then restarted
    capN = 0;
    setDesc(4, 0, 840, 2, 1, 0, 1);
    setDesc(8, 0, 860, 3, 0, 1, 1);
    regWrite(A_HEAD, 4);
    wait (capN >= 2);
    descWrite(4, 8);
    waitIdle("R13 clash");
    repeat (10) @(negedge clk);
    check("R13 clash count", 32'(capN), 2);
    descRead(7, d); check("R13 clash eoq", d, modeOf(1, 0, 0, 2) | EOQ);
    descRead(4, d); check("R13 clash link kept", d, 8);
    regWrite(A_HEAD, 8);
    waitIdle("R13 restart");
    check("R13 restart count", 32'(capN), 5);
    checkStream("R13 restart", 2, 860, 3, 0, 1);
    descRead(11, d); check("R13 restart mode", d, modeOf(0, 1, 0, 3) | EOQ);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule